// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block sits beside a two-port memory and gives the two sides a way to signal each other. It observes the control and address lines that each side already drives into the memory. Two addresses at the top of the space are reserved as mailboxes, one for each direction. When one side writes the mailbox that faces the opposite side, an active-low interrupt is raised toward that opposite side. The receiver then reads the mailbox to take the message, and that read drops its interrupt.

The block holds one flag per direction, updated on the rising clock edge from the access presented in that cycle. The message words themselves stay in the memory, so the block keeps only two bits of state. Reset is asynchronous and active low.

Top module: `mbox_irq`

## Requirements
- R1: While reset is asserted, and after it is released with no qualifying access, both interrupt outputs are high.
- R2: A left-side write (lf_sel_n=0, lf_wr_n=0) to address 0x3FF (all ones) drives rt_irq_n low from the next clock edge.
- R3: A right-side write (rt_sel_n=0, rt_wr_n=0) to address 0x3FE drives lf_irq_n low from the next clock edge.
- R4: A right-side read (rt_sel_n=0, rt_wr_n=1, rt_oe_n=0) of address 0x3FF returns rt_irq_n high from the next clock edge.
- R5: A left-side read (lf_sel_n=0, lf_wr_n=1, lf_oe_n=0) of address 0x3FE returns lf_irq_n high from the next clock edge.
- R6: An access missing any qualifier changes no flag: a write with the select high, or a read with the select high or the output enable high.
- R7: When a set and a clear of the same flag fall in the same cycle, the flag ends up set (output low).
- R8: A side writing its own receive mailbox, or reading the mailbox that faces the other side, changes neither flag.
- R9: With no set or clear in a cycle, both outputs keep their value across the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lf_sel_n | input | 1 | Left-side select, active low |
| lf_wr_n | input | 1 | Left-side direction: 0 write, 1 read |
| lf_oe_n | input | 1 | Left-side output enable, active low |
| lf_addr | input | ADDR_W (10) | Left-side address |
| rt_sel_n | input | 1 | Right-side select, active low |
| rt_wr_n | input | 1 | Right-side direction: 0 write, 1 read |
| rt_oe_n | input | 1 | Right-side output enable, active low |
| rt_addr | input | ADDR_W (10) | Right-side address |
| lf_irq_n | output | 1 | Interrupt toward the left side, active low |
| rt_irq_n | output | 1 | Interrupt toward the right side, active low |

## Verification
Each flag drives its output directly, so a wrong bit of state appears on an interrupt pin one clock edge after the access that caused it and stays there until the next qualifying set or clear. A corrupted flag is therefore either a missed interrupt, which stays wrong until the sender writes again, or a spurious one, which stays wrong until the receiver reads its mailbox. Random traffic biased toward the two reserved addresses, plus directed collisions of set and clear, make both kinds of error visible within a few cycles.

// File: rtl/mbox_irq.sv
`timescale 1ns/1ps
module mbox_irq #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lf_sel_n,
  input  logic              lf_wr_n,
  input  logic              lf_oe_n,
  input  logic [ADDR_W-1:0] lf_addr,
  input  logic              rt_sel_n,
  input  logic              rt_wr_n,
  input  logic              rt_oe_n,
  input  logic [ADDR_W-1:0] rt_addr,
  output logic              lf_irq_n,
  output logic              rt_irq_n
);
  localparam logic [ADDR_W-1:0] BOX_TO_RT = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_TO_LF = BOX_TO_RT - 1'b1;

  logic lf_wr_go, lf_rd_go, rt_wr_go, rt_rd_go;
  logic set_rt, clr_rt, set_lf, clr_lf;
  logic rt_pend, lf_pend;

  assign lf_wr_go = !lf_sel_n && !lf_wr_n;
  assign lf_rd_go = !lf_sel_n &&  lf_wr_n && !lf_oe_n;
  assign rt_wr_go = !rt_sel_n && !rt_wr_n;
  assign rt_rd_go = !rt_sel_n &&  rt_wr_n && !rt_oe_n;

  assign set_rt = lf_wr_go && (lf_addr == BOX_TO_RT);
  assign clr_rt = rt_rd_go && (rt_addr == BOX_TO_RT);
  assign set_lf = rt_wr_go && (rt_addr == BOX_TO_LF);
  assign clr_lf = lf_rd_go && (lf_addr == BOX_TO_LF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_pend <= 1'b0;
      lf_pend <= 1'b0;
    end else begin
      if (set_rt)      rt_pend <= 1'b1;
      else if (clr_rt) rt_pend <= 1'b0;
      if (set_lf)      lf_pend <= 1'b1;
      else if (clr_lf) lf_pend <= 1'b0;
    end
  end

  assign rt_irq_n = !rt_pend;
  assign lf_irq_n = !lf_pend;
endmodule

// File: rtl/mbox_irq_chk.sv
`timescale 1ns/1ps
module mbox_irq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lf_sel_n,
  input logic              lf_wr_n,
  input logic              lf_oe_n,
  input logic [ADDR_W-1:0] lf_addr,
  input logic              rt_sel_n,
  input logic              rt_wr_n,
  input logic              rt_oe_n,
  input logic [ADDR_W-1:0] rt_addr,
  input logic              lf_irq_n,
  input logic              rt_irq_n
);
  logic [ADDR_W-1:0] top_a, next_a;
  logic l_set, l_clr, r_set, r_clr;
  assign top_a  = '1;
  assign next_a = top_a - 1'b1;
  assign r_set = !lf_sel_n && !lf_wr_n && lf_addr == top_a;
  assign r_clr = !rt_sel_n && rt_wr_n && !rt_oe_n && rt_addr == top_a;
  assign l_set = !rt_sel_n && !rt_wr_n && rt_addr == next_a;
  assign l_clr = !lf_sel_n && lf_wr_n && !lf_oe_n && lf_addr == next_a;

  AST_RT_RAISE: assert property (@(posedge clk) disable iff (!rst_n) r_set |=> !rt_irq_n); // R2
  AST_LF_RAISE: assert property (@(posedge clk) disable iff (!rst_n) l_set |=> !lf_irq_n); // R3
  AST_RT_DROP: assert property (@(posedge clk) disable iff (!rst_n) (r_clr && !r_set) |=> rt_irq_n); // R4
  AST_LF_DROP: assert property (@(posedge clk) disable iff (!rst_n) (l_clr && !l_set) |=> lf_irq_n); // R5
  AST_RT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!r_set && !r_clr) |=> $stable(rt_irq_n)); // R9
  AST_LF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!l_set && !l_clr) |=> $stable(lf_irq_n)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (r_set && r_clr) |=> !rt_irq_n); // R7
endmodule

bind mbox_irq mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbox_irq_bench.sv
`timescale 1ns/1ps
module mbox_irq_bench;
  localparam int AW = 10;
  localparam logic [AW-1:0] A_TO_RT = 10'h3FF;
  localparam logic [AW-1:0] A_TO_LF = 10'h3FE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lf_sel_n = 1'b1, lf_wr_n = 1'b1, lf_oe_n = 1'b1;
  logic rt_sel_n = 1'b1, rt_wr_n = 1'b1, rt_oe_n = 1'b1;
  logic [AW-1:0] lf_addr = '0, rt_addr = '0;
  logic lf_irq_n, rt_irq_n;
  logic exp_lf = 1'b0, exp_rt = 1'b0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mbox_irq #(.ADDR_W(AW)) u_mbox_irq (
    .clk(clk), .rst_n(rst_n),
    .lf_sel_n(lf_sel_n), .lf_wr_n(lf_wr_n), .lf_oe_n(lf_oe_n), .lf_addr(lf_addr),
    .rt_sel_n(rt_sel_n), .rt_wr_n(rt_wr_n), .rt_oe_n(rt_oe_n), .rt_addr(rt_addr),
    .lf_irq_n(lf_irq_n), .rt_irq_n(rt_irq_n)
  );

  function automatic logic next_flag(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  task automatic check(string tag);
    total += 2;
    if (rt_irq_n !== !exp_rt) begin
      bad++;
      $display("FAIL %s rt_irq_n actual=%b expected=%b", tag, rt_irq_n, !exp_rt);
    end
    if (lf_irq_n !== !exp_lf) begin
      bad++;
      $display("FAIL %s lf_irq_n actual=%b expected=%b", tag, lf_irq_n, !exp_lf);
    end
  endtask

  // called at a falling edge: apply access, predict, wait one cycle, check
  task automatic step(logic ls, logic lw, logic lo, logic [AW-1:0] la,
                      logic rs, logic rw, logic ro, logic [AW-1:0] ra, string tag);
    lf_sel_n = ls; lf_wr_n = lw; lf_oe_n = lo; lf_addr = la;
    rt_sel_n = rs; rt_wr_n = rw; rt_oe_n = ro; rt_addr = ra;
    exp_rt = next_flag(exp_rt, !ls && !lw && la == A_TO_RT, !rs && rw && !ro && ra == A_TO_RT);
    exp_lf = next_flag(exp_lf, !rs && !rw && ra == A_TO_LF, !ls && lw && !lo && la == A_TO_LF);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(string tag);
    step(1, 1, 1, '0, 1, 1, 1, '0, tag);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int r = int'($urandom_range(0, 3));
    if (r == 0) return A_TO_RT;
    if (r == 1) return A_TO_LF;
    return AW'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");
    idle("R1 idle");

    step(0, 0, 1, A_TO_RT, 1, 1, 1, '0, "R2 left write 3FF");
    idle("R9 hold rt");
    step(1, 1, 1, '0, 0, 0, 1, A_TO_LF, "R3 right write 3FE");
    step(1, 1, 1, '0, 0, 1, 1, A_TO_RT, "R6 read with oe high");
    step(1, 1, 1, '0, 1, 1, 0, A_TO_RT, "R6 read with select high");
    step(1, 1, 0, A_TO_LF, 1, 1, 1, '0, "R6 left read select high");
    step(0, 1, 0, A_TO_RT, 0, 1, 0, A_TO_LF, "R8 reads of wrong mailbox");
    step(1, 1, 1, '0, 0, 1, 0, A_TO_RT, "R4 right read 3FF");
    step(0, 1, 0, A_TO_LF, 1, 1, 1, '0, "R5 left read 3FE");
    step(1, 0, 1, A_TO_RT, 1, 1, 1, '0, "R6 write select high");
    step(0, 0, 1, A_TO_LF, 0, 0, 1, A_TO_RT, "R8 own mailbox writes");
    step(0, 0, 1, A_TO_RT, 0, 1, 0, A_TO_RT, "R7 rt set and clear");
    step(0, 1, 0, A_TO_LF, 0, 0, 1, A_TO_LF, "R7 lf set and clear");
    step(0, 0, 0, A_TO_RT, 1, 1, 1, '0, "R2 write with oe low");
    idle("R9 hold both");
    step(1, 1, 1, '0, 0, 0, 0, A_TO_RT, "R8 right write 3FF is not a read");

    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom), pick_addr(),
           1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom), pick_addr(),
           "random R2 R3 R4 R5 R7 R9");
    end

    rst_n = 1'b0;
    #1;
    exp_lf = 1'b0; exp_rt = 1'b0;
    check("R1 reset mid-run");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule